// File: doc/BRIEF.md
# ALU Condition and Control Flag Unit

This block takes an arithmetic or logical operation on two operands and returns the result together with its six condition flags: carry, auxiliary carry, parity, zero, sign and overflow. The operation runs on either the low 8 bits of the operands or the full 16 bits. A small stream stage carries the result out. The input side accepts an operation when `in_valid` and `in_ready` are both high. The accepted result is presented on the next cycle and stays there, unchanged, until `out_ready` is seen high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. An operation offered while `in_ready` is low is not taken and has no effect.

The block also keeps a 16-bit flag word. Each accepted operation writes its condition flags into this word. The same word holds three control bits: single-step enable, maskable-interrupt enable and the string-direction bit (set means addresses step downward). Software-style controls can load the whole word, or set and clear the control bits one at a time. The control bits are also brought out as separate decoded pins for the logic that uses them.

Top module: `alu_flag_unit`

## Requirements
- R1: With `in_op`=0 (add), the result is a+b+cin, truncated to the selected width. Carry is the carry out of bit 7 when `in_wide`=0 and out of bit 15 when `in_wide`=1.
- R2: With `in_op`=1 (subtract), the result is a−b−cin, truncated to the selected width. Carry is set exactly when a borrow leaves the top bit, that is, when a < b+cin unsigned within the width.
- R3: Overflow is set when the signed add or subtract result lies outside the signed range of the selected width. With `in_op`=2 (AND) or `in_op`=3 (OR), both carry and overflow are 0.
- R4: For add, auxiliary carry is the carry from bit 3 into bit 4. For subtract, it is the borrow from bit 4 into bit 3. For AND and OR, the presented auxiliary flag and flag word bit 4 keep the value they had before the operation.
- R5: Parity is 1 when result bits 7..0 hold an even number of ones and 0 when they hold an odd number. This holds in 16-bit mode as well.
- R6: In 8-bit mode, the operand bits 15..8 are ignored and result bits 15..8 are 0. Zero is set when the result within the width is 0. Sign is a copy of bit 7 in 8-bit mode and of bit 15 in 16-bit mode.
- R7: `in_ready` = !`out_valid` || `out_ready`. An operation accepted at an edge appears with `out_valid`=1 after that edge. The output is held stable while `out_ready` is low. Offers made while `in_ready` is low are ignored.
- R8: Flag word layout: carry at bit 0, parity at bit 2, auxiliary at bit 4, zero at bit 6, sign at bit 7, trap at bit 8, interrupt enable at bit 9, direction at bit 10, overflow at bit 11. Bits 15..12 always read 1 and bits 1, 3 and 5 always read 0. After reset the word is 16'hF000. The condition bits take the accepted operation's flags in the same cycle that `out_valid` rises.
- R9: `ctl_set[i]` sets control bit i and `ctl_clr[i]` clears it, where i=0 is trap, i=1 is interrupt enable and i=2 is direction. If both are high for the same bit, set wins. `trap_en`, `int_en` and `dir_down` show these bits.
- R10: `ctl_load` writes (`ctl_wdata` & 16'h0FD5) | 16'hF000 into the flag word. The load takes precedence over set, clear and any condition update from an operation accepted in the same cycle. That operation's output is still presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 2 | 0 add, 1 subtract, 2 AND, 3 OR |
| in_wide | input | 1 | 1 selects 16-bit, 0 selects 8-bit |
| in_a | input | 16 | First operand |
| in_b | input | 16 | Second operand |
| in_cin | input | 1 | Carry or borrow in for add and subtract |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 16 | Result |
| out_carry | output | 1 | Carry or borrow flag |
| out_aux | output | 1 | Auxiliary carry flag |
| out_parity | output | 1 | Even parity of result bits 7..0 |
| out_zero | output | 1 | Zero flag |
| out_sign | output | 1 | Sign flag |
| out_ovf | output | 1 | Signed overflow flag |
| ctl_load | input | 1 | Load the whole flag word |
| ctl_wdata | input | 16 | Data for the flag word load |
| ctl_set | input | 3 | Set trap, interrupt enable, direction |
| ctl_clr | input | 3 | Clear trap, interrupt enable, direction |
| flag_word | output | 16 | Flag word |
| trap_en | output | 1 | Single-step enable |
| int_en | output | 1 | Maskable interrupt enable |
| dir_down | output | 1 | String addresses step downward |

## Verification
Three situations are hard to reach from the ports. The first is an auxiliary flag that must survive a logical operation: its expected value depends on whichever arithmetic operation came last. The bench therefore keeps a running model of the flag word and interleaves logical operations with arithmetic ones throughout a sweep of every 8-bit first operand against edge-value second operands. The second is the cycle in which the consumer drains a held result while a new operation is waiting. The stimulus stalls `out_ready` with a second offer pending, then releases it so that the drain and the accept fall on the same edge. The third is a load that collides with an accepted operation, which is driven in a single cycle so that precedence is observable.

// File: rtl/afu_pkg.sv
package afu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_OR  = 2'd3
  } afu_op_e;

  localparam int FLAG_W = 16;
  localparam int N_CTL  = 3;

  localparam int BIT_CF = 0;
  localparam int BIT_PF = 2;
  localparam int BIT_AF = 4;
  localparam int BIT_ZF = 6;
  localparam int BIT_SF = 7;
  localparam int BIT_TF = 8;
  localparam int BIT_IF = 9;
  localparam int BIT_DF = 10;
  localparam int BIT_OF = 11;

  localparam logic [FLAG_W-1:0] FIXED_ONES   = 16'hF000;
  localparam logic [FLAG_W-1:0] DEFINED_MASK = 16'h0FD5;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } afu_cond_t;

endpackage

// File: rtl/afu_arith.sv
module afu_arith
  import afu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  afu_op_e           op,
  input  logic              wide,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              carry,
  output logic              aux,
  output logic              ovf,
  output logic              is_logic
);
  localparam int HALF_W = DATA_W / 2;
  localparam int EXT_W  = DATA_W + 1;

  logic [DATA_W-1:0] am, bm;
  logic [EXT_W-1:0]  sum, dif, raw;
  logic [NIB_W:0]    nsum, ndif;
  logic              a_top, b_top, r_top;

  always_comb begin
    am   = wide ? a : {{HALF_W{1'b0}}, a[HALF_W-1:0]};
    bm   = wide ? b : {{HALF_W{1'b0}}, b[HALF_W-1:0]};
    sum  = {1'b0, am} + {1'b0, bm} + {{DATA_W{1'b0}}, cin};
    dif  = {1'b0, am} - {1'b0, bm} - {{DATA_W{1'b0}}, cin};
    nsum = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    ndif = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin};
    is_logic = (op == OP_AND) || (op == OP_OR);

    case (op)
      OP_ADD: begin raw = sum; aux = nsum[NIB_W]; end
      OP_SUB: begin raw = dif; aux = ndif[NIB_W]; end
      OP_AND: begin raw = {1'b0, am & bm}; aux = 1'b0; end
      default: begin raw = {1'b0, am | bm}; aux = 1'b0; end
    endcase

    res   = wide ? raw[DATA_W-1:0] : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
    a_top = wide ? am[DATA_W-1] : am[HALF_W-1];
    b_top = wide ? bm[DATA_W-1] : bm[HALF_W-1];
    r_top = wide ? res[DATA_W-1] : res[HALF_W-1];
    carry = is_logic ? 1'b0 : (wide ? raw[DATA_W] : raw[HALF_W]);

    case (op)
      OP_ADD:  ovf = (a_top == b_top) && (r_top != a_top);
      OP_SUB:  ovf = (a_top != b_top) && (r_top != a_top);
      default: ovf = 1'b0;
    endcase
  end
endmodule

// File: rtl/afu_status.sv
module afu_status #(
  parameter int DATA_W = 16,
  parameter int PAR_W  = 8
) (
  input  logic [DATA_W-1:0] res,
  input  logic              wide,
  output logic              parity,
  output logic              zero,
  output logic              sign
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    parity = ~^res[PAR_W-1:0];
    zero   = wide ? ~|res : ~|res[HALF_W-1:0];
    sign   = wide ? res[DATA_W-1] : res[HALF_W-1];
  end
endmodule

// File: rtl/afu_flagreg.sv
module afu_flagreg
  import afu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  afu_cond_t         cond,
  input  logic              ctl_load,
  input  logic [FLAG_W-1:0] ctl_wdata,
  input  logic [N_CTL-1:0]  ctl_set,
  input  logic [N_CTL-1:0]  ctl_clr,
  output logic [FLAG_W-1:0] flags
);
  afu_cond_t          cond_q;
  afu_cond_t          cond_ld;
  logic [N_CTL-1:0]   ctl_q;
  logic               unused_wdata;

  assign unused_wdata = ^(ctl_wdata & ~DEFINED_MASK);

  always_comb begin
    cond_ld.cf = ctl_wdata[BIT_CF];
    cond_ld.pf = ctl_wdata[BIT_PF];
    cond_ld.af = ctl_wdata[BIT_AF];
    cond_ld.zf = ctl_wdata[BIT_ZF];
    cond_ld.sf = ctl_wdata[BIT_SF];
    cond_ld.of = ctl_wdata[BIT_OF];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cond_q <= '0;
    else if (ctl_load) cond_q <= cond_ld;
    else if (upd)      cond_q <= cond;
  end

  for (genvar g = 0; g < N_CTL; g++) begin : g_ctl
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bit_q <= 1'b0;
      else if (ctl_load)   bit_q <= ctl_wdata[BIT_TF+g];
      else if (ctl_set[g]) bit_q <= 1'b1;
      else if (ctl_clr[g]) bit_q <= 1'b0;
    end
    assign ctl_q[g] = bit_q;
  end

  always_comb begin
    flags         = FIXED_ONES;
    flags[BIT_CF] = cond_q.cf;
    flags[BIT_PF] = cond_q.pf;
    flags[BIT_AF] = cond_q.af;
    flags[BIT_ZF] = cond_q.zf;
    flags[BIT_SF] = cond_q.sf;
    flags[BIT_OF] = cond_q.of;
    for (int i = 0; i < N_CTL; i++) flags[BIT_TF+i] = ctl_q[i];
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import afu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [1:0]  in_op,
  input  logic        in_wide,
  input  logic [15:0] in_a,
  input  logic [15:0] in_b,
  input  logic        in_cin,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_result,
  output logic        out_carry,
  output logic        out_aux,
  output logic        out_parity,
  output logic        out_zero,
  output logic        out_sign,
  output logic        out_ovf,
  input  logic        ctl_load,
  input  logic [15:0] ctl_wdata,
  input  logic [2:0]  ctl_set,
  input  logic [2:0]  ctl_clr,
  output logic [15:0] flag_word,
  output logic        trap_en,
  output logic        int_en,
  output logic        dir_down
);
  localparam int DATA_W = 16;

  afu_op_e           op_e;
  logic [DATA_W-1:0] res_c;
  logic              carry_c, aux_c, ovf_c, logic_c;
  logic              par_c, zero_c, sign_c;
  afu_cond_t         cond_c;
  logic              accept;
  logic              valid_q;
  logic [DATA_W-1:0] res_q;
  afu_cond_t         cond_q;

  assign op_e     = afu_op_e'(in_op);
  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  afu_arith #(.DATA_W(DATA_W), .NIB_W(4)) u_arith (
    .a(in_a), .b(in_b), .op(op_e), .wide(in_wide), .cin(in_cin),
    .res(res_c), .carry(carry_c), .aux(aux_c), .ovf(ovf_c), .is_logic(logic_c)
  );

  afu_status #(.DATA_W(DATA_W), .PAR_W(8)) u_status (
    .res(res_c), .wide(in_wide),
    .parity(par_c), .zero(zero_c), .sign(sign_c)
  );

  always_comb begin
    cond_c.cf = carry_c;
    cond_c.pf = par_c;
    cond_c.af = logic_c ? flag_word[BIT_AF] : aux_c;
    cond_c.zf = zero_c;
    cond_c.sf = sign_c;
    cond_c.of = ovf_c;
  end

  afu_flagreg u_flagreg (
    .clk(clk), .rst_n(rst_n), .upd(accept), .cond(cond_c),
    .ctl_load(ctl_load), .ctl_wdata(ctl_wdata),
    .ctl_set(ctl_set), .ctl_clr(ctl_clr), .flags(flag_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         valid_q <= 1'b0;
    else if (accept)    valid_q <= 1'b1;
    else if (out_ready) valid_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      cond_q <= '0;
    end else if (accept) begin
      res_q  <= res_c;
      cond_q <= cond_c;
    end
  end

  assign out_valid  = valid_q;
  assign out_result = res_q;
  assign out_carry  = cond_q.cf;
  assign out_aux    = cond_q.af;
  assign out_parity = cond_q.pf;
  assign out_zero   = cond_q.zf;
  assign out_sign   = cond_q.sf;
  assign out_ovf    = cond_q.of;
  assign trap_en    = flag_word[BIT_TF];
  assign int_en     = flag_word[BIT_IF];
  assign dir_down   = flag_word[BIT_DF];
endmodule

// File: rtl/afu_checker.sv
module afu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [1:0]  in_op,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_result,
  input logic        out_carry,
  input logic        out_aux,
  input logic        out_parity,
  input logic        out_zero,
  input logic        out_ovf,
  input logic        ctl_load,
  input logic [15:0] ctl_wdata,
  input logic [2:0]  ctl_set,
  input logic [2:0]  ctl_clr,
  input logic [15:0] flag_word,
  input logic        trap_en,
  input logic        int_en
);
  // R7
  a_r7_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R7
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_carry)
                                && $stable(out_ovf) && $stable(out_aux));
  // R3
  a_r3_logic_clear: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op[1] |=> !out_carry && !out_ovf);
  // R4
  a_r4_logic_af: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op[1] |=> out_aux == $past(flag_word[4]));
  // R5
  a_r5_parity: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_parity == ~^out_result[7:0]);
  // R6
  a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_zero == (out_result == 16'h0000));
  // R8
  a_r8_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !ctl_load |=> (flag_word[0] == out_carry) && (flag_word[2] == out_parity)
                                          && (flag_word[6] == out_zero) && (flag_word[11] == out_ovf));
  // R9
  a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_load && ctl_set[0] |=> trap_en);
  // R9
  a_r9_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_load && ctl_clr[1] && !ctl_set[1] |=> !int_en);
  // R10
  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_load |=> flag_word == (($past(ctl_wdata) & 16'h0FD5) | 16'hF000));
endmodule

bind alu_flag_unit afu_checker u_afu_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_carry(out_carry), .out_aux(out_aux), .out_parity(out_parity), .out_zero(out_zero),
  .out_ovf(out_ovf), .ctl_load(ctl_load), .ctl_wdata(ctl_wdata), .ctl_set(ctl_set),
  .ctl_clr(ctl_clr), .flag_word(flag_word), .trap_en(trap_en), .int_en(int_en)
);

// File: tb/alu_flag_unit_bench.sv
`timescale 1ns/1ps
module alu_flag_unit_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, in_valid, in_ready, in_wide, in_cin, out_valid, out_ready;
  logic [1:0]  in_op;
  logic [15:0] in_a, in_b, out_result, ctl_wdata, flag_word;
  logic        out_carry, out_aux, out_parity, out_zero, out_sign, out_ovf;
  logic        ctl_load, trap_en, int_en, dir_down;
  logic [2:0]  ctl_set, ctl_clr;

  alu_flag_unit u_alu_flag_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_wide(in_wide), .in_a(in_a), .in_b(in_b), .in_cin(in_cin), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_carry(out_carry), .out_aux(out_aux),
    .out_parity(out_parity), .out_zero(out_zero), .out_sign(out_sign), .out_ovf(out_ovf),
    .ctl_load(ctl_load), .ctl_wdata(ctl_wdata), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
    .flag_word(flag_word), .trap_en(trap_en), .int_en(int_en), .dir_down(dir_down)
  );

  int checks = 0;
  int failures = 0;
  logic [15:0] model;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_op(int op, bit wide, int a, int b, bit cin, bit with_load = 1'b0, int ldata = 0);
    int w, mask, half, ai, bi, sa, sb, sr, full, res;
    bit cf, af, of, pf, zf, sf;
    string rtag, ctag;
    w = wide ? 16 : 8;
    mask = (1 << w) - 1;
    half = 1 << (w - 1);
    ai = a & mask;
    bi = b & mask;
    sa = (ai >= half) ? ai - (1 << w) : ai;
    sb = (bi >= half) ? bi - (1 << w) : bi;
    cf = 0; of = 0; af = model[4];
    case (op)
      0: begin
        full = ai + bi + cin; res = full & mask; cf = ((full >> w) & 1) != 0;
        af = ((a & 15) + (b & 15) + cin) > 15;
        sr = sa + sb + cin; of = (sr > half - 1) || (sr < -half);
        rtag = "R1"; ctag = "R1";
      end
      1: begin
        full = ai - bi - cin; res = full & mask; cf = ai < bi + cin;
        af = (a & 15) < ((b & 15) + cin);
        sr = sa - sb - cin; of = (sr > half - 1) || (sr < -half);
        rtag = "R2"; ctag = "R2";
      end
      2: begin res = ai & bi; rtag = "R6"; ctag = "R3"; end
      default: begin res = ai | bi; rtag = "R6"; ctag = "R3"; end
    endcase
    pf = ($countones(res & 255) % 2) == 0;
    zf = (res == 0);
    sf = ((res >> (w - 1)) & 1) != 0;

    @(negedge clk);
    in_valid = 1'b1; in_op = op[1:0]; in_wide = wide; in_a = a[15:0]; in_b = b[15:0]; in_cin = cin;
    ctl_load = with_load; ctl_wdata = ldata[15:0];
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; ctl_load = 1'b0;
    if (with_load) model = (ldata[15:0] & 16'h0FD5) | 16'hF000;
    else begin
      model[0] = cf; model[2] = pf; model[4] = af; model[6] = zf; model[7] = sf; model[11] = of;
    end
    chk("R7", "out_valid", int'(out_valid), 1);
    chk(rtag, "result", int'(out_result), res);
    chk(ctag, "carry", int'(out_carry), int'(cf));
    chk("R4", "aux", int'(out_aux), int'(af));
    chk("R5", "parity", int'(out_parity), int'(pf));
    chk("R6", "zero", int'(out_zero), int'(zf));
    chk("R6", "sign", int'(out_sign), int'(sf));
    chk("R3", "overflow", int'(out_ovf), int'(of));
    chk(with_load ? "R10" : "R8", "flag_word", int'(flag_word), int'(model));
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk("R7", "drained", int'(out_valid), 0);
  endtask

  task automatic ctl_cycle(string tag, bit load, int wdata, int set, int clr);
    @(negedge clk);
    ctl_load = load; ctl_wdata = wdata[15:0]; ctl_set = set[2:0]; ctl_clr = clr[2:0];
    @(posedge clk);
    @(negedge clk);
    ctl_load = 1'b0; ctl_set = 3'b000; ctl_clr = 3'b000;
    if (load) model = (wdata[15:0] & 16'h0FD5) | 16'hF000;
    else
      for (int i = 0; i < 3; i++) begin
        if (set[i]) model[8+i] = 1'b1;
        else if (clr[i]) model[8+i] = 1'b0;
      end
    chk(tag, "flag_word", int'(flag_word), int'(model));
    chk("R9", "trap_en", int'(trap_en), int'(model[8]));
    chk("R9", "int_en", int'(int_en), int'(model[9]));
    chk("R9", "dir_down", int'(dir_down), int'(model[10]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit [31:0] x;
    int blist[8];
    rst_n = 1'b0; in_valid = 1'b0; in_op = 2'd0; in_wide = 1'b0; in_a = '0; in_b = '0;
    in_cin = 1'b0; out_ready = 1'b0; ctl_load = 1'b0; ctl_wdata = '0; ctl_set = '0; ctl_clr = '0;
    model = 16'hF000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "reset flag_word", int'(flag_word), 16'hF000);
    chk("R7", "reset out_valid", int'(out_valid), 0);
    chk("R7", "reset in_ready", int'(in_ready), 1);

    ctl_cycle("R9", 0, 0, 3'b101, 3'b000);
    ctl_cycle("R9", 0, 0, 3'b010, 3'b010);
    ctl_cycle("R9", 0, 0, 3'b000, 3'b001);
    ctl_cycle("R9", 0, 0, 3'b000, 3'b110);
    ctl_cycle("R10", 1, 16'hFFFF, 3'b000, 3'b000);
    ctl_cycle("R10", 1, 16'h0000, 3'b111, 3'b000);
    ctl_cycle("R10", 1, 16'h0A5A, 3'b000, 3'b111);

    do_op(0, 1, 16'h7FFF, 16'h0001, 0);
    do_op(0, 1, 16'hFFFF, 16'h0001, 0);
    do_op(0, 1, 16'hFFFF, 16'h0000, 1);
    do_op(1, 1, 16'h8000, 16'h0001, 0);
    do_op(1, 1, 16'h0000, 16'h0000, 1);
    do_op(1, 1, 16'h1234, 16'h1234, 0);
    do_op(3, 1, 16'h0100, 16'h0000, 0);
    do_op(2, 1, 16'hF0F0, 16'h0FF0, 1);
    do_op(0, 0, 16'hAB7F, 16'h5501, 0);
    do_op(1, 0, 16'h1280, 16'h3401, 0);

    blist = '{0, 1, 15, 16, 127, 128, 255, 0};
    for (int a = 0; a < 256; a++)
      for (int k = 0; k < 8; k++)
        for (int op = 0; op < 4; op++)
          for (int c = 0; c < 2; c++) begin
            int b, ain, bin;
            b = (k == 7) ? (a ^ 8'h5A) : blist[k];
            ain = (((~a) & 255) << 8) | a;
            bin = ((b * 37 + 11) & 255) << 8 | b;
            do_op(op, 0, ain, bin, c[0]);
          end

    x = 32'h1234_5678;
    for (int n = 0; n < 3000; n++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      do_op(int'(x[1:0]), 1, int'(x[31:16]), int'(x[23:8]), x[2]);
    end

    @(negedge clk);
    in_valid = 1'b1; in_op = 2'd0; in_wide = 1'b0; in_a = 16'h0012; in_b = 16'h0034; in_cin = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_op = 2'd3; in_a = 16'h00F0; in_b = 16'h000F;
    chk("R7", "stalled in_ready", int'(in_ready), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R7", "held result", int'(out_result), 16'h0046);
    chk("R7", "held valid", int'(out_valid), 1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7", "drain and accept", int'(out_result), 16'h00FF);
    chk("R7", "drain and accept valid", int'(out_valid), 1);
    model = (model & ~16'h08D5) | 16'h0084;
    chk("R4", "flag_word after stall", int'(flag_word), int'(model));
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk("R7", "empty after drain", int'(out_valid), 0);

    do_op(0, 0, 16'h000F, 16'h0001, 0, 1'b1, 16'h0300);
    do_op(2, 0, 16'h00FF, 16'h0000, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule